// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the standard 64-byte Type-0 configuration header of an endpoint function and serves it over a simple single-beat config port. Each request carries a byte offset, an access width in bytes, write data and a write strobe. The block answers every request, read or write, after a fixed number of clock cycles set by a parameter. Multi-byte fields are little-endian, so the lowest offset holds the least significant byte.

The identification fields, class code, interrupt pin, grant/latency hints and the reset values of all writable registers are parameters. Six base address slots are built from a generate loop. Each slot has its own size parameter, which must be zero or a power of two. Software sizes a slot by writing all ones and reading back the size mask. A later address write then opens a decode window for that slot. The decode outputs give the window's first and last address and an enable, with a fixed I/O or memory window offset added to the programmed address. The expansion-ROM register has its own probe value. Writes are filtered by offset and by width. Writes to fields that are allowed to drop them are discarded silently. Any other disallowed write is discarded and raises a one-cycle protocol-error pulse.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After synchronous reset every register reads back its parameter default (default set: word 0x00 = 0x7A11C0DE, word 0x04 = 0x00100000, word 0x08 = 0x02000003, word 0x3C = 0x1008010B, slots 0/1/2 = 0x0, 0x1, 0x8) and all six decode enables are 0.
- R2: Widths of 1, 2 and 4 bytes are accepted, and the bytes come back little-endian starting at the offset. Any other width gives a response with the error flag set, read data 0 and no state change.
- R3: An access with offset plus width above 64 (so every offset at or above 0x40) gives a response with the error flag set and read data 0, changes nothing, and raises no protocol-error pulse.
- R4: Every request produces exactly one response (`rsp_valid` high for one cycle) LATENCY cycles after the edge that takes the request. The default LATENCY is 2.
- R5: A 4-byte write of 0xFFFFFFFF to a slot (offsets 0x10 to 0x24, slot = (offset-0x10)/4) stores ~(size-1), with the low type bits kept from the old value. Bit 0 set means I/O, and 2 type bits are kept. Otherwise it is memory, and 4 type bits are kept. The decode outputs do not change.
- R6: Any other 4-byte slot write stores the written address with the type bits kept from the old value. If the masked address is nonzero, the decode base becomes that address plus IO_WIN (I/O slot) or MEM_WIN (memory slot), the last address becomes base+size-1 and the enable is set. A masked address of zero leaves the decode outputs unchanged.
- R7: A 4-byte write of 0xFFFFFFFE to the expansion-ROM register at 0x30 stores 0xFFFFFFFF. Any other 4-byte value is stored unchanged.
- R8: A 4-byte or 2-byte write at 0x04 replaces the 16-bit command field with the low data half. The status half (0x06) is unchanged.
- R9: 1-byte writes at 0x0C (cache line), 0x0D (latency timer) and 0x3C (interrupt line) store the byte.
- R10: 1-byte writes to revision/class code (0x08 to 0x0B), interrupt pin (0x3D), minimum grant (0x3E) and maximum latency (0x3F) are ignored without a protocol-error pulse.
- R11: Every other in-range write is ignored. `prot_err` goes high for exactly the one cycle after the edge that takes the write.
- R12: A slot size that is neither zero nor a power of two stops elaboration. A slot of size zero never sets its decode enable, and its probe reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the header |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Width or range error on the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| prot_err | output | 1 | One-cycle pulse on a disallowed write |
| bar_en | output | 6 | Per-slot decode enable |
| bar_base | output | 6*DEC_W | Per-slot decode base, slot i at [i*DEC_W +: DEC_W] |
| bar_last | output | 6*DEC_W | Per-slot last decoded address |

## Verification
A wrong slot type mask or a bad probe value shows up in the read data of the very next read of that slot, LATENCY cycles after that read is issued. A wrong window offset or size shows on `bar_base` and `bar_last` one edge after the address write. A misclassified offset shows in one of two ways. Either `prot_err` fails to pulse in the cycle after the write, or a later read returns a changed value where the old one should have stayed. Decode enables that move without a write, and responses that arrive off the fixed latency, are flagged in the cycle where they happen.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int HDR_BYTES = 64;
    localparam int HDR_WORDS = HDR_BYTES / 4;
    localparam int NUM_BARS  = 6;
    localparam int DATA_W    = 32;

    // Offsets whose position is fixed by the header layout
    localparam logic [7:0] OFS_CMD      = 8'h04;
    localparam logic [7:0] OFS_REV      = 8'h08;
    localparam logic [7:0] OFS_CLASS_HI = 8'h0B;
    localparam logic [7:0] OFS_CLINE    = 8'h0C;
    localparam logic [7:0] OFS_LTIMER   = 8'h0D;
    localparam logic [7:0] OFS_SLOT0    = 8'h10;
    localparam logic [7:0] OFS_SLOT5    = 8'h24;
    localparam logic [7:0] OFS_ROM      = 8'h30;
    localparam logic [7:0] OFS_ILINE    = 8'h3C;
    localparam logic [7:0] OFS_MAXLAT   = 8'h3F;

    localparam logic [31:0] IO_TYPE_MASK  = 32'h0000_0003;
    localparam logic [31:0] MEM_TYPE_MASK = 32'h0000_000F;
    localparam logic [31:0] ROM_PROBE     = 32'hFFFF_FFFE;

    typedef enum logic [3:0] {
        WK_NONE,
        WK_CMD,
        WK_CLINE,
        WK_LTIMER,
        WK_ILINE,
        WK_SLOT,
        WK_ROM,
        WK_QUIET,
        WK_DENY
    } wr_kind_e;

    typedef struct packed {
        logic     bad;
        wr_kind_e kind;
        logic [2:0] slot;
    } req_class_t;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    function automatic logic size_legal(input logic [31:0] v);
        return (v & (v - 32'd1)) == 32'd0;
    endfunction

    function automatic logic [31:0] width_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_hdr_req_decode.sv
module cfg_hdr_req_decode
    import cfg_hdr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              write,
    output req_class_t        cls
);
    localparam int SUM_W = ADDR_W + 1;

    logic             size_ok;
    logic [SUM_W-1:0] end_ofs;
    logic [7:0]       a8;
    logic             hi_zero;

    assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    assign end_ofs = SUM_W'(addr) + SUM_W'(size);
    assign a8      = addr[7:0];
    assign hi_zero = (addr >> 8) == '0;

    always_comb begin
        cls.bad  = !size_ok || (end_ofs > SUM_W'(HDR_BYTES)) || !hi_zero;
        cls.kind = WK_NONE;
        cls.slot = 3'(a8[5:2] - 4'd4);
        if (write && !cls.bad) begin
            cls.kind = WK_DENY;
            case (size)
                3'd4: begin
                    if (a8 == OFS_CMD)
                        cls.kind = WK_CMD;
                    else if (a8 >= OFS_SLOT0 && a8 <= OFS_SLOT5 && a8[1:0] == 2'b00)
                        cls.kind = WK_SLOT;
                    else if (a8 == OFS_ROM)
                        cls.kind = WK_ROM;
                end
                3'd2: begin
                    if (a8 == OFS_CMD)
                        cls.kind = WK_CMD;
                end
                default: begin
                    if (a8 == OFS_CLINE)
                        cls.kind = WK_CLINE;
                    else if (a8 == OFS_LTIMER)
                        cls.kind = WK_LTIMER;
                    else if (a8 == OFS_ILINE)
                        cls.kind = WK_ILINE;
                    else if ((a8 >= OFS_REV && a8 <= OFS_CLASS_HI) ||
                             (a8 > OFS_ILINE && a8 <= OFS_MAXLAT))
                        cls.kind = WK_QUIET;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_hdr_slot.sv
module cfg_hdr_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] INIT    = 32'h0,
    parameter logic [31:0] SIZE    = 32'h0,
    parameter int          DEC_W   = 40,
    parameter logic [DEC_W-1:0] IO_WIN  = '0,
    parameter logic [DEC_W-1:0] MEM_WIN = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    output logic [31:0]      value,
    output logic [DEC_W-1:0] dec_base,
    output logic [DEC_W-1:0] dec_last,
    output logic             dec_en
);
    localparam logic [31:0]      PROBE_VAL = ~(SIZE - 32'd1);
    localparam logic             HAS_RANGE = (SIZE != 32'd0);
    localparam logic [DEC_W-1:0] SPAN      = DEC_W'(SIZE) - DEC_W'(1);

    generate
        if (!size_legal(SIZE)) begin : g_bad_size
            $error("cfg_hdr_slot: SIZE must be zero or a power of two");
        end
    endgenerate

    logic [31:0]      val_q;
    logic [DEC_W-1:0] base_q;
    logic             en_q;
    logic             is_io;
    logic [31:0]      tmask;
    logic [31:0]      addr_part;
    logic [DEC_W-1:0] win;

    assign is_io     = val_q[0];
    assign tmask     = is_io ? IO_TYPE_MASK : MEM_TYPE_MASK;
    assign win       = is_io ? IO_WIN : MEM_WIN;
    assign addr_part = (wdata == 32'hFFFF_FFFF) ? (PROBE_VAL & ~tmask) : (wdata & ~tmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= INIT;
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            val_q <= addr_part | (val_q & tmask);
            if (wdata != 32'hFFFF_FFFF && addr_part != 32'd0) begin
                base_q <= DEC_W'(addr_part) + win;
                en_q   <= HAS_RANGE;
            end
        end
    end

    assign value    = val_q;
    assign dec_base = base_q;
    assign dec_last = base_q + SPAN;
    assign dec_en   = en_q;
endmodule

// File: rtl/cfg_hdr_rsp_pipe.sv
module cfg_hdr_rsp_pipe
    import cfg_hdr_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  rsp_t din,
    output rsp_t dout
);
    rsp_t stage [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[LAT-1];
endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
    import cfg_hdr_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DEC_W       = 40,
    parameter int          LATENCY     = 2,
    parameter logic [15:0] VENDOR      = 16'hC0DE,
    parameter logic [15:0] DEVICE      = 16'h7A11,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [7:0]  REVISION    = 8'h03,
    parameter logic [15:0] CMD_INIT    = 16'h0000,
    parameter logic [15:0] STATUS_VAL  = 16'h0010,
    parameter logic [7:0]  CLINE_INIT  = 8'h00,
    parameter logic [7:0]  LTIMER_INIT = 8'h00,
    parameter logic [7:0]  HDR_TYPE    = 8'h00,
    parameter logic [7:0]  SELFTEST    = 8'h00,
    parameter logic [31:0] CIS_PTR     = 32'h0,
    parameter logic [15:0] SUB_VENDOR  = 16'hC0DE,
    parameter logic [15:0] SUB_ID      = 16'h0001,
    parameter logic [31:0] ROM_INIT    = 32'h0,
    parameter logic [7:0]  ILINE_INIT  = 8'h0B,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GNT     = 8'h08,
    parameter logic [7:0]  MAX_LAT     = 8'h10,
    parameter logic [5:0][31:0] SLOT_INIT = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
    parameter logic [5:0][31:0] SLOT_SIZE = {32'h0, 32'h0, 32'h0, 32'h0001_0000, 32'h100, 32'h1000},
    parameter logic [DEC_W-1:0] IO_WIN  = 40'h01_0000_0000,
    parameter logic [DEC_W-1:0] MEM_WIN = 40'h02_0000_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [2:0]                req_size,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [31:0]               rsp_rdata,
    output logic                      prot_err,
    output logic [NUM_BARS-1:0]       bar_en,
    output logic [NUM_BARS*DEC_W-1:0] bar_base,
    output logic [NUM_BARS*DEC_W-1:0] bar_last
);
    localparam int WIDX_W = $clog2(HDR_WORDS);

    req_class_t  rc;
    logic [15:0] cmd_q;
    logic [7:0]  cline_q, ltimer_q, iline_q;
    logic [31:0] rom_q;
    logic        prot_q;
    logic [31:0] slot_val [NUM_BARS];
    logic [31:0] words [HDR_WORDS];
    logic [WIDX_W-1:0] widx;
    logic [31:0] nxt_word;
    logic [63:0] win;
    logic [31:0] rd_now;
    logic        take;
    rsp_t        rsp_in, rsp_out;

    assign take = req_valid && !rc.bad;

    cfg_hdr_req_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .write(req_write),
        .cls  (rc)
    );

    generate
        for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
            logic wr_g;
            assign wr_g = req_valid && rc.kind == WK_SLOT && rc.slot == 3'(g);
            cfg_hdr_slot #(
                .INIT   (SLOT_INIT[g]),
                .SIZE   (SLOT_SIZE[g]),
                .DEC_W  (DEC_W),
                .IO_WIN (IO_WIN),
                .MEM_WIN(MEM_WIN)
            ) u_slot (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_g),
                .wdata   (req_wdata),
                .value   (slot_val[g]),
                .dec_base(bar_base[g*DEC_W +: DEC_W]),
                .dec_last(bar_last[g*DEC_W +: DEC_W]),
                .dec_en  (bar_en[g])
            );
        end
    endgenerate

    // Writable scalar registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_INIT;
            cline_q  <= CLINE_INIT;
            ltimer_q <= LTIMER_INIT;
            iline_q  <= ILINE_INIT;
            rom_q    <= ROM_INIT;
            prot_q   <= 1'b0;
        end else begin
            prot_q <= req_valid && rc.kind == WK_DENY;
            if (req_valid) begin
                case (rc.kind)
                    WK_CMD:    cmd_q    <= req_wdata[15:0];
                    WK_CLINE:  cline_q  <= req_wdata[7:0];
                    WK_LTIMER: ltimer_q <= req_wdata[7:0];
                    WK_ILINE:  iline_q  <= req_wdata[7:0];
                    WK_ROM:    rom_q    <= (req_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Header image, one 32-bit word per four offsets
    always_comb begin
        for (int w = 0; w < HDR_WORDS; w++) words[w] = 32'h0;
        words[0]  = {DEVICE, VENDOR};
        words[1]  = {STATUS_VAL, cmd_q};
        words[2]  = {CLASS_CODE, REVISION};
        words[3]  = {SELFTEST, HDR_TYPE, ltimer_q, cline_q};
        for (int s = 0; s < NUM_BARS; s++) words[4+s] = slot_val[s];
        words[10] = CIS_PTR;
        words[11] = {SUB_ID, SUB_VENDOR};
        words[12] = rom_q;
        words[15] = {MAX_LAT, MIN_GNT, INT_PIN, iline_q};
    end

    assign widx     = req_addr[WIDX_W+1:2];
    assign nxt_word = (widx == WIDX_W'(HDR_WORDS - 1)) ? 32'h0 : words[widx + WIDX_W'(1)];
    assign win      = {nxt_word, words[widx]} >> {req_addr[1:0], 3'b000};
    assign rd_now   = win[31:0] & width_mask(req_size);

    always_comb begin
        rsp_in.vld  = req_valid;
        rsp_in.err  = req_valid && rc.bad;
        rsp_in.data = (take && !req_write) ? rd_now : 32'h0;
    end

    cfg_hdr_rsp_pipe #(.LAT(LATENCY)) u_pipe (
        .clk (clk),
        .rst (rst),
        .din (rsp_in),
        .dout(rsp_out)
    );

    assign rsp_valid = rsp_out.vld;
    assign rsp_err   = rsp_out.err;
    assign rsp_rdata = rsp_out.data;
    assign prot_err  = prot_q;
endmodule

// File: rtl/cfg_hdr_regfile_chk.sv
module cfg_hdr_regfile_chk #(
    parameter int LAT = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        prot_err,
    input logic [5:0]  bar_en
);
    logic [LAT-1:0] issued;

    always_ff @(posedge clk) begin
        if (rst) issued <= '0;
        else     issued <= (issued << 1) | LAT'(req_valid);
    end

    a_r4_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == issued[LAT-1]);

    a_r2_err_has_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);

    a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == 32'h0);

    a_r6_dec_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(bar_en));

    a_r11_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> $past(req_valid && req_write));
endmodule

bind cfg_hdr_regfile cfg_hdr_regfile_chk #(.LAT(LATENCY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .prot_err (prot_err),
    .bar_en   (bar_en)
);

// File: tb/cfg_hdr_regfile_tb_top.sv
`timescale 1ns/1ps
module cfg_hdr_regfile_tb_top;
    localparam int LAT = 2;
    localparam int DW  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [2:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err, prot_err;
    logic [31:0]   rsp_rdata;
    logic [5:0]    bar_en;
    logic [6*DW-1:0] bar_base, bar_last;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfg_hdr_regfile #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .prot_err(prot_err), .bar_en(bar_en),
        .bar_base(bar_base), .bar_last(bar_last)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; checks response timing (R4) and returns data, error and pulse
    task automatic xfer(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output logic pe);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        pe = prot_err;
        if (LAT > 1) check("R4 no early response", 64'(rsp_valid), 64'd0);
        for (int k = 1; k < LAT; k++) begin
            @(posedge clk); #1;
            if (k == 1) check("R11 pulse lasts one cycle", 64'(prot_err), 64'd0);
        end
        check("R4 response at latency", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata; er = rsp_err;
        @(posedge clk); #1;
        check("R4 single response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input logic [2:0] sz,
                             input logic [31:0] exp);
        logic [31:0] d; logic e, p;
        xfer(1'b0, a, sz, 32'h0, d, e, p);
        check(req, 64'(d), 64'(exp));
        check(req, 64'(e), 64'd0);
    endtask

    task automatic wr_expect(input string req, input logic [7:0] a, input logic [2:0] sz,
                             input logic [31:0] wd, input logic exp_err, input logic exp_pe);
        logic [31:0] d; logic e, p;
        xfer(1'b1, a, sz, wd, d, e, p);
        check(req, 64'(e), 64'(exp_err));
        check(req, 64'(p), 64'(exp_pe));
    endtask

    task automatic t_reset();
        rd_expect("R1 id word", 8'h00, 3'd4, 32'h7A11C0DE);
        rd_expect("R1 cmd/status", 8'h04, 3'd4, 32'h00100000);
        rd_expect("R1 class/rev", 8'h08, 3'd4, 32'h02000003);
        rd_expect("R1 int word", 8'h3C, 3'd4, 32'h1008010B);
        rd_expect("R1 slot0", 8'h10, 3'd4, 32'h0);
        rd_expect("R1 slot1", 8'h14, 3'd4, 32'h1);
        rd_expect("R1 slot2", 8'h18, 3'd4, 32'h8);
        check("R1 enables clear", 64'(bar_en), 64'd0);
    endtask

    task automatic t_widths();
        logic [31:0] d; logic e, p;
        rd_expect("R2 byte read", 8'h01, 3'd1, 32'h000000C0);
        rd_expect("R2 half read", 8'h02, 3'd2, 32'h00007A11);
        rd_expect("R2 unaligned byte", 8'h3D, 3'd1, 32'h00000001);
        xfer(1'b0, 8'h00, 3'd3, 32'h0, d, e, p);
        check("R2 size 3 error", 64'(e), 64'd1);
        check("R2 size 3 data", 64'(d), 64'd0);
        wr_expect("R2 bad width write", 8'h0C, 3'd3, 32'h55, 1'b1, 1'b0);
        rd_expect("R2 no change", 8'h0C, 3'd1, 32'h0);
    endtask

    task automatic t_range();
        logic [31:0] d; logic e, p;
        xfer(1'b0, 8'h40, 3'd4, 32'h0, d, e, p);
        check("R3 offset 0x40 error", 64'(e), 64'd1);
        check("R3 offset 0x40 data", 64'(d), 64'd0);
        xfer(1'b0, 8'h3E, 3'd4, 32'h0, d, e, p);
        check("R3 crossing error", 64'(e), 64'd1);
        rd_expect("R3 last byte ok", 8'h3F, 3'd1, 32'h10);
        wr_expect("R3 write above", 8'h80, 3'd4, 32'hFFFFFFFF, 1'b1, 1'b0);
    endtask

    task automatic t_probe();
        wr_expect("R5 probe mem", 8'h10, 3'd4, 32'hFFFFFFFF, 1'b0, 1'b0);
        rd_expect("R5 mem size", 8'h10, 3'd4, 32'hFFFFF000);
        wr_expect("R5 probe io", 8'h14, 3'd4, 32'hFFFFFFFF, 1'b0, 1'b0);
        rd_expect("R5 io size", 8'h14, 3'd4, 32'hFFFFFF01);
        wr_expect("R5 probe pref", 8'h18, 3'd4, 32'hFFFFFFFF, 1'b0, 1'b0);
        rd_expect("R5 pref size", 8'h18, 3'd4, 32'hFFFF0008);
        check("R5 no decode", 64'(bar_en), 64'd0);
    endtask

    task automatic t_assign();
        wr_expect("R6 mem addr", 8'h10, 3'd4, 32'h12345677, 1'b0, 1'b0);
        rd_expect("R6 mem type kept", 8'h10, 3'd4, 32'h12345670);
        check("R6 mem en", 64'(bar_en[0]), 64'd1);
        check("R6 mem base", 64'(bar_base[0*DW +: DW]), 64'h02_1234_5670);
        check("R6 mem last", 64'(bar_last[0*DW +: DW]), 64'h02_1234_666F);
        wr_expect("R6 io addr", 8'h14, 3'd4, 32'hABCD0002, 1'b0, 1'b0);
        rd_expect("R6 io type kept", 8'h14, 3'd4, 32'hABCD0001);
        check("R6 io base", 64'(bar_base[1*DW +: DW]), 64'h01_ABCD_0000);
        check("R6 io last", 64'(bar_last[1*DW +: DW]), 64'h01_ABCD_00FF);
        wr_expect("R6 zero masked", 8'h18, 3'd4, 32'h00000007, 1'b0, 1'b0);
        rd_expect("R6 zero masked value", 8'h18, 3'd4, 32'h8);
        check("R6 zero masked no en", 64'(bar_en[2]), 64'd0);
        wr_expect("R6 clear addr", 8'h10, 3'd4, 32'h0, 1'b0, 1'b0);
        check("R6 clear keeps en", 64'(bar_en[0]), 64'd1);
        check("R6 clear keeps base", 64'(bar_base[0*DW +: DW]), 64'h02_1234_5670);
        wr_expect("R12 empty slot addr", 8'h1C, 3'd4, 32'h50000000, 1'b0, 1'b0);
        rd_expect("R12 empty slot value", 8'h1C, 3'd4, 32'h50000000);
        check("R12 empty slot no en", 64'(bar_en[3]), 64'd0);
        wr_expect("R12 empty probe", 8'h1C, 3'd4, 32'hFFFFFFFF, 1'b0, 1'b0);
        rd_expect("R12 empty probe value", 8'h1C, 3'd4, 32'h0);
    endtask

    task automatic t_rom_cmd();
        wr_expect("R7 rom probe", 8'h30, 3'd4, 32'hFFFFFFFE, 1'b0, 1'b0);
        rd_expect("R7 rom all ones", 8'h30, 3'd4, 32'hFFFFFFFF);
        wr_expect("R7 rom value", 8'h30, 3'd4, 32'h000C0001, 1'b0, 1'b0);
        rd_expect("R7 rom stored", 8'h30, 3'd4, 32'h000C0001);
        wr_expect("R8 cmd word", 8'h04, 3'd4, 32'hFFFF0147, 1'b0, 1'b0);
        rd_expect("R8 status kept", 8'h04, 3'd4, 32'h00100147);
        wr_expect("R8 cmd half", 8'h04, 3'd2, 32'h00000006, 1'b0, 1'b0);
        rd_expect("R8 cmd half value", 8'h04, 3'd4, 32'h00100006);
    endtask

    task automatic t_bytes();
        wr_expect("R9 cline", 8'h0C, 3'd1, 32'h10, 1'b0, 1'b0);
        wr_expect("R9 ltimer", 8'h0D, 3'd1, 32'h40, 1'b0, 1'b0);
        wr_expect("R9 iline", 8'h3C, 3'd1, 32'h05, 1'b0, 1'b0);
        rd_expect("R9 word 0x0C", 8'h0C, 3'd4, 32'h00004010);
        rd_expect("R9 iline value", 8'h3C, 3'd1, 32'h05);
        wr_expect("R10 pin", 8'h3D, 3'd1, 32'hEE, 1'b0, 1'b0);
        wr_expect("R10 revision", 8'h08, 3'd1, 32'hEE, 1'b0, 1'b0);
        wr_expect("R10 class", 8'h0B, 3'd1, 32'hEE, 1'b0, 1'b0);
        rd_expect("R10 class/rev kept", 8'h08, 3'd4, 32'h02000003);
        rd_expect("R10 int word kept", 8'h3C, 3'd4, 32'h10080105);
    endtask

    task automatic t_denied();
        wr_expect("R11 id word", 8'h00, 3'd4, 32'hDEADBEEF, 1'b0, 1'b1);
        rd_expect("R11 id kept", 8'h00, 3'd4, 32'h7A11C0DE);
        wr_expect("R11 header type", 8'h0E, 3'd1, 32'hFF, 1'b0, 1'b1);
        wr_expect("R11 half at 0x0C", 8'h0C, 3'd2, 32'hFFFF, 1'b0, 1'b1);
        rd_expect("R11 0x0C kept", 8'h0C, 3'd4, 32'h00004010);
        wr_expect("R11 cis", 8'h28, 3'd4, 32'h1234, 1'b0, 1'b1);
        rd_expect("R11 cis kept", 8'h28, 3'd4, 32'h0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #1 check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        check("R1 no pulse after reset", 64'(prot_err), 64'd0);
        t_reset();
        t_widths();
        t_range();
        t_probe();
        t_assign();
        t_rom_cmd();
        t_bytes();
        t_denied();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule